// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to eight interrupt sources into sticky request bits and turns them into one interrupt line to a CPU. A rising source only needs to be high for a single clock to be remembered. Software works on the request bits through a small register bus. Writing a mask to one address sets request bits, and writing a mask to another address clears them. A read/write mask register picks which requests may reach the CPU. A read-only view shows the requests that survive that mask.

The CPU line is high when a pending bit exists and a gate flag is set. A pulse on the acknowledge input closes the gate. The gate opens again by itself once nothing is pending. The line comes straight from the registered state, so it rises in the first cycle in which a request meets its enable, with no extra cycle of delay. The source count is a parameter from 1 to 8. Register bits above that count read as zero.

Register offsets: 0 request (read only), 1 enable (read/write), 2 pending (read only), 3 set mask (write only), 4 clear mask (write only), 5 gate flag in bit 0 (read only). Offsets 6 and 7 read as zero.

Top module: `irq_hub`

## Requirements
- R1: While reset is held, the request, enable, pending and gate registers read 0x00, `cpu_irq` is low, and `rdata` is 0x00 when no read is presented.
- R2: The enable register (offset 1) reads back the last value written to it, for example 0x55, then 0xAA, then 0x00.
- R3: A write to offset 3 ORs the written bits into the request register. Writing 0xAA and then 0x55 leaves 0xFF.
- R4: A write to offset 4 clears every request bit that is 1 in the written value. From 0xFF, clearing 0x71 leaves 0x8E, and clearing 0x85 after that leaves 0x0A.
- R5: A source input that is high at a clock edge sets its request bit, and the bit stays set after the source falls. Sources whose bit is already set leave the register unchanged.
- R6: The pending register (offset 2) reads as request AND enable, bit by bit. Writes to offsets 0, 2 and 5 change nothing.
- R7: `cpu_irq` equals (pending is nonzero) AND gate flag. It goes high in the cycle right after the edge that makes a pending bit appear while the gate is open.
- R8: `cpu_ack` high at an edge clears the gate flag (bit 0 of offset 5). At any other edge where pending is zero, the flag is set.
- R9: When a source and a clear write hit the same bit at the same edge, the bit ends up set. Offsets 3 and 4 read as zero.
- R10: With NSRC sources, request, enable and pending bits at NSRC and above read as zero, even after 0xFF is written to offsets 1 and 3. Offsets 6 and 7 read as zero.
- R11: `ready` is always high. `rdata` is driven only while `sel` and `rd_en` are high and is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus select |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when no read |
| ready | output | 1 | Always high |
| src | input | NSRC | Interrupt sources |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| cpu_ack | input | 1 | Interrupt acknowledge from the CPU |

## Verification
The bench builds two copies that share one bus. The first has the full eight sources and carries the directed and random register traffic. The second has NSRC = 3, so writes of 0xFF must read back as 0x07. That copy shows the masking of upper bits, which a full-width build cannot show. Running both copies from the same bus writes also checks that the source count changes only which bits exist, not how the set, clear and gate actions behave.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int MAX_SRC = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_REQ  = 3'd0,
    A_ENA  = 3'd1,
    A_PEND = 3'd2,
    A_TRIG = 3'd3,
    A_CLR  = 3'd4,
    A_GATE = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   trig_mask,
  output logic [NSRC-1:0]   clr_mask,
  output logic              ena_we,
  output logic [NSRC-1:0]   ena_wd
);
  logic wr_hit;
  assign wr_hit    = sel && wr_en;
  assign trig_mask = (wr_hit && addr == A_TRIG) ? wdata[NSRC-1:0] : '0;
  assign clr_mask  = (wr_hit && addr == A_CLR)  ? wdata[NSRC-1:0] : '0;
  assign ena_we    = wr_hit && addr == A_ENA;
  assign ena_wd    = wdata[NSRC-1:0];
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] trig_mask,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            ena_we,
  input  logic [NSRC-1:0] ena_wd,
  output logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] ena_q,
  output logic [NSRC-1:0] pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[i] <= 1'b0;
        ena_q[i] <= 1'b0;
      end else begin
        req_q[i] <= (req_q[i] & ~clr_mask[i]) | src[i] | trig_mask[i];
        if (ena_we) ena_q[i] <= ena_wd[i];
      end
    end

    // R5, R9
    src_sets_chk: assert property (@(posedge clk) disable iff (rst)
      src[i] |=> req_q[i]);
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (req_q[i] && !clr_mask[i]) |=> req_q[i]);
    // R3
    trig_sets_chk: assert property (@(posedge clk) disable iff (rst)
      trig_mask[i] |=> req_q[i]);
  end

  assign pend = req_q & ena_q;

  // R2
  ena_write_chk: assert property (@(posedge clk) disable iff (rst)
    ena_we |=> ena_q == $past(ena_wd));
endmodule

// File: rtl/irq_cpu_gate.sv
module irq_cpu_gate #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend,
  input  logic            cpu_ack,
  output logic            gate_q,
  output logic            cpu_irq
);
  logic any_pend;
  assign any_pend = |pend;

  always_ff @(posedge clk) begin
    if (rst)           gate_q <= 1'b0;
    else if (cpu_ack)  gate_q <= 1'b0;
    else if (!any_pend) gate_q <= 1'b1;
  end

  assign cpu_irq = any_pend & gate_q;

  // R8
  ack_drops_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_irq);
  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_pend && !cpu_ack) |=> gate_q);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  input  logic [NSRC-1:0]   src,
  output logic              cpu_irq,
  input  logic              cpu_ack
);
  localparam int PAD_W = DATA_W - NSRC;

  logic [NSRC-1:0] trig_mask, clr_mask, ena_wd, req_q, ena_q, pend;
  logic            ena_we, gate_q;

  irq_bus_dec #(.NSRC(NSRC)) u_dec (
    .sel(sel), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .trig_mask(trig_mask), .clr_mask(clr_mask),
    .ena_we(ena_we), .ena_wd(ena_wd)
  );

  irq_req_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .src(src),
    .trig_mask(trig_mask), .clr_mask(clr_mask),
    .ena_we(ena_we), .ena_wd(ena_wd),
    .req_q(req_q), .ena_q(ena_q), .pend(pend)
  );

  irq_cpu_gate #(.NSRC(NSRC)) u_gate (
    .clk(clk), .rst(rst), .pend(pend), .cpu_ack(cpu_ack),
    .gate_q(gate_q), .cpu_irq(cpu_irq)
  );

  function automatic logic [DATA_W-1:0] widen(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  always_comb begin
    rdata = '0;
    if (sel && rd_en) begin
      case (addr)
        A_REQ:   rdata = widen(req_q);
        A_ENA:   rdata = widen(ena_q);
        A_PEND:  rdata = widen(pend);
        A_GATE:  rdata = {{(DATA_W-1){1'b0}}, gate_q};
        default: rdata = '0;
      endcase
    end
  end

  assign ready = 1'b1;

  initial begin
    if (NSRC < 1 || NSRC > MAX_SRC || PAD_W < 0)
      $error("irq_hub: NSRC must be 1..8");
  end

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (req_q & ena_q) != '0);
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd_en) |-> rdata == '0);
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0, cpu_ack = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, src = '0, rdata, rdata3;
  logic [2:0] src3 = '0;
  logic       ready, ready3, cpu_irq, cpu_irq3;

  int checks = 0, fails = 0;
  logic [7:0] req_m, ena_m;
  logic       gate_m;
  logic [2:0] req3_m, ena3_m;
  logic       gate3_m;

  always #5 clk = ~clk;

  irq_hub #(.NSRC(8)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .ready(ready),
    .src(src), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack));

  irq_hub #(.NSRC(3)) u_dut3 (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata3), .ready(ready3),
    .src(src3), .cpu_irq(cpu_irq3), .cpu_ack(cpu_ack));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] next_req(input logic [7:0] r, input logic [7:0] s,
                                          input logic [7:0] t, input logic [7:0] c);
    return (r & ~c) | s | t;
  endfunction

  // one clock: drive, edge, model update, release
  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] s, input logic ack);
    logic [7:0] t, c;
    sel = w; wr_en = w; addr = a; wdata = d; src = s; src3 = s[2:0]; cpu_ack = ack;
    t = (w && a == 3'd3) ? d : 8'h00;
    c = (w && a == 3'd4) ? d : 8'h00;
    @(posedge clk);
    if (rst) begin
      req_m = 0; ena_m = 0; gate_m = 0; req3_m = 0; ena3_m = 0; gate3_m = 0;
    end else begin
      gate_m  = ack ? 1'b0 : (((req_m & ena_m) == 0) ? 1'b1 : gate_m);
      gate3_m = ack ? 1'b0 : (((req3_m & ena3_m) == 0) ? 1'b1 : gate3_m);
      req_m  = next_req(req_m, s, t, c);
      req3_m = 3'(next_req({5'b0, req3_m}, s, t, c) & 8'h07);
      if (w && a == 3'd1) begin ena_m = d; ena3_m = d[2:0]; end
    end
    #1;
    sel = 0; wr_en = 0; wdata = 0; src = 0; src3 = 0; cpu_ack = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v, output logic [7:0] v3);
    sel = 1; rd_en = 1; addr = a;
    #1;
    v = rdata; v3 = rdata3;
    sel = 0; rd_en = 0;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v, v3;
    rd(3'd0, v, v3); chk({tag, " R5 req"}, v, req_m); chk({tag, " R10 req3"}, v3, {5'b0, req3_m});
    rd(3'd2, v, v3); chk({tag, " R6 pend"}, v, req_m & ena_m);
    rd(3'd5, v, v3); chk({tag, " R8 gate"}, v, {7'b0, gate_m});
    chk({tag, " R7 irq"}, {7'b0, cpu_irq}, {7'b0, |(req_m & ena_m) & gate_m});
    chk({tag, " R7 irq3"}, {7'b0, cpu_irq3}, {7'b0, |(req3_m & ena3_m) & gate3_m});
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v3;
    int seed;
    seed = 17;
    void'($urandom(seed));
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    // R1: reads while reset is held
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v, v3); chk("R1 reset read", v, 8'h00);
    end
    chk("R1 irq low", {7'b0, cpu_irq}, 8'h00);
    chk("R11 idle rdata", rdata, 8'h00);
    chk("R11 ready", {7'b0, ready}, 8'h01);
    rst = 0;
    step(0, 0, 0, 0, 0);

    // R2
    step(1, 1, 8'h55, 0, 0); rd(1, v, v3); chk("R2 ena 55", v, 8'h55);
    step(1, 1, 8'hAA, 0, 0); rd(1, v, v3); chk("R2 ena AA", v, 8'hAA);
    step(1, 1, 8'h00, 0, 0); rd(1, v, v3); chk("R2 ena 00", v, 8'h00);
    // R3
    step(1, 3, 8'hAA, 0, 0); rd(0, v, v3); chk("R3 trig AA", v, 8'hAA);
    step(1, 3, 8'h55, 0, 0); rd(0, v, v3); chk("R3 trig FF", v, 8'hFF);
    // R4
    step(1, 4, 8'h71, 0, 0); rd(0, v, v3); chk("R4 clr 8E", v, 8'h8E);
    step(1, 4, 8'h85, 0, 0); rd(0, v, v3); chk("R4 clr 0A", v, 8'h0A);
    // R9: trig/clr read zero
    rd(3, v, v3); chk("R9 trig reads 0", v, 8'h00);
    rd(4, v, v3); chk("R9 clr reads 0", v, 8'h00);
    // R5: source pulses
    step(1, 4, 8'hFF, 0, 0);
    step(0, 0, 0, 8'hAA, 0); rd(0, v, v3); chk("R5 src AA", v, 8'hAA);
    step(0, 0, 0, 8'hA1, 0); rd(0, v, v3); chk("R5 src repeat", v, 8'hAB);
    // R9: source beats clear on same bit
    step(1, 4, 8'h0F, 8'h02, 0); rd(0, v, v3); chk("R9 set wins", v, 8'hA2);
    // R6: ignored writes
    step(1, 0, 8'h00, 0, 0); step(1, 2, 8'hFF, 0, 0); step(1, 5, 8'h00, 0, 0);
    rd(0, v, v3); chk("R6 req unchanged", v, 8'hA2);
    rd(1, v, v3); chk("R6 ena unchanged", v, 8'h00);
    // R7: irq rises right after enable write
    chk("R7 irq low", {7'b0, cpu_irq}, 8'h00);
    step(1, 1, 8'h02, 0, 0);
    chk("R7 irq immediate", {7'b0, cpu_irq}, 8'h01);
    rd(2, v, v3); chk("R6 pend", v, 8'h02);
    // R8: ack closes gate, reopens after pending clears
    step(0, 0, 0, 0, 1);
    chk("R8 irq after ack", {7'b0, cpu_irq}, 8'h00);
    rd(5, v, v3); chk("R8 gate closed", v, 8'h00);
    step(1, 4, 8'h02, 0, 0);
    step(0, 0, 0, 0, 0);
    rd(5, v, v3); chk("R8 gate reopened", v, 8'h01);
    // R10: narrow instance
    step(1, 3, 8'hFF, 0, 0); step(1, 1, 8'hFF, 0, 0);
    rd(0, v, v3); chk("R10 req3 masked", v3, 8'h07);
    rd(1, v, v3); chk("R10 ena3 masked", v3, 8'h07);
    rd(2, v, v3); chk("R10 pend3 masked", v3, 8'h07);
    rd(6, v, v3); chk("R10 addr6 zero", v, 8'h00);
    rd(7, v, v3); chk("R10 addr7 zero", v, 8'h00);
    check_all("directed");

    // random traffic
    for (int n = 0; n < 500; n++) begin
      int op;
      logic [7:0] d, s;
      op = $urandom_range(0, 5);
      d = 8'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
      case (op)
        0: step(1, 3, d & 8'($urandom), s, 0);
        1: step(1, 4, d, s, 0);
        2: step(1, 1, d, s, 0);
        3: step(0, 0, 0, s, $urandom_range(0, 1) == 1);
        4: step(1, 3'($urandom_range(5, 7)), d, s, 0);
        default: step(0, 0, 0, s, 0);
      endcase
      check_all("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule